// File: doc/BRIEF.md
# Serial SRAM slave on an SPI bus

This block models a byte-addressed static RAM that is reached over a four-wire SPI link running in mode 0. The clock idles low, the bus master changes data while the clock is low, and both sides sample on the rising clock edge, most significant bit first. A transaction opens when the active-low select falls. The first byte is an opcode: 0x02 starts a write and 0x03 starts a read. Three address bytes follow, high byte first, and the block uses only the low `AddrBits` bits of the 24 received. A full 128 KiB array is built with `AddrBits = 17`. The default is a smaller array so that default elaboration stays light.

After the address, a write stores every complete byte that arrives. A read returns stored bytes while the master clocks in dummy bytes. In both cases the address steps up by one per byte and wraps from the top of the array to zero. This continues until select rises. Releasing select drops any partial byte and returns the decoder to the opcode phase. The serial inputs are brought into the block clock domain by two-flop synchronisers, so the serial clock half period must be at least four block clock cycles.

Top module: `spi_sram`

## Requirements
- R1: After reset, `sdoOe` and `sdo` are both 0.
- R2: `sdi` is sampled on rising `sclk` edges, most significant bit first, and eight rising edges make one byte.
- R3: Opcode 0x02 followed by a three-byte address stores each later complete byte at consecutive addresses, starting at the given address.
- R4: Opcode 0x03 followed by a three-byte address returns the stored bytes MSB first, starting at that address. `sdo` changes only after falling `sclk` edges, and the first data bit is valid before the first rising edge of the data phase.
- R5: Address bytes are taken high byte first, and only the low `AddrBits` bits select a location. The upper bits have no effect.
- R6: During streaming, the address advances by one per byte and wraps from 2^AddrBits-1 to 0.
- R7: An opcode other than 0x02 or 0x03 makes the rest of the transaction inert: `sdoOe` stays 0 and memory is unchanged.
- R8: `sdoOe` is 1 only while select is low and a read is in its data phase. It is 0 during the opcode and address bytes, during any write, and after select rises.
- R9: A rise of select discards a partial byte (it is never stored) and resets the decoder, so the next byte after select falls is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock, idles low (mode 0) |
| sdi | input | 1 | Serial data from the bus master |
| sdo | output | 1 | Serial data to the bus master; held 0 when not enabled |
| sdoOe | output | 1 | Output enable for `sdo` |

## Verification
Two actions can fall in the same cycle. One is the rising edge that completes a byte, which triggers the store and the address step. The other is the select release that wipes the bit counter and the decoder. The bench provokes the collision by releasing select four bits into a data byte that directly follows a complete one. It then reads both locations back. The complete byte must be present and the following location must hold its earlier content. A second collision comes at the top of the array, where a store and the wrap of the address happen on the same edge. A burst written across that boundary must read back unbroken, both from its start address and from address zero.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam int unsigned ADDR_BYTES = 3;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;   // capture sdi bit
    logic addrLoad;  // fold received byte into address
    logic addrInc;   // step address after a data byte
    logic memWrite;  // store the completed byte
    logic fetch;     // read array at current address into buffer
    logic txLoad;    // move buffer into output shifter
    logic txShift;   // advance output shifter one bit
  } dp_strobe_t;

endpackage

// File: rtl/spi_sram_ctrl.sv
module spi_sram_ctrl
  import spi_sram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic [7:0] rxByte,
  output logic       sdiBit,
  output dp_strobe_t st,
  output logic       oe
);

  localparam int unsigned IdxW = $clog2(ADDR_BYTES);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(ADDR_BYTES - 1);

  logic [2:0] sclkSync;
  logic [1:0] csSync;
  logic [1:0] sdiSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= 2'b11;
      sdiSync  <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      csSync   <= {csSync[0], csN};
      sdiSync  <= {sdiSync[0], sdi};
    end
  end

  logic sel, rise, fall, byteDone;
  assign sel    = ~csSync[1];
  assign rise   = sclkSync[1] & ~sclkSync[2];
  assign fall   = ~sclkSync[1] & sclkSync[2];
  assign sdiBit = sdiSync[1];

  phase_t          phase;
  logic [2:0]      bitCnt;
  logic [IdxW-1:0] addrIdx;
  logic            isRead;
  logic            fetchPend;
  logic            oeQ;

  assign byteDone = sel & rise & (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      addrIdx   <= '0;
      isRead    <= 1'b0;
      fetchPend <= 1'b0;
      oeQ       <= 1'b0;
    end else if (!sel) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      addrIdx   <= '0;
      fetchPend <= 1'b0;
      oeQ       <= 1'b0;
    end else begin
      fetchPend <= 1'b0;
      if (rise) bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        unique case (phase)
          PH_CMD: begin
            addrIdx <= '0;
            if (rxByte == OP_WRITE) begin
              phase  <= PH_ADDR;
              isRead <= 1'b0;
            end else if (rxByte == OP_READ) begin
              phase  <= PH_ADDR;
              isRead <= 1'b1;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            addrIdx <= addrIdx + 1'b1;
            if (addrIdx == LastIdx) begin
              phase     <= isRead ? PH_READ : PH_WRITE;
              fetchPend <= isRead;
            end
          end
          PH_READ:  fetchPend <= 1'b1;
          PH_WRITE: ;
          PH_SKIP:  ;
          default:  phase <= PH_SKIP;
        endcase
      end
      if (phase == PH_READ && fall && bitCnt == 3'd0) oeQ <= 1'b1;
    end
  end

  always_comb begin
    st          = '0;
    st.shiftIn  = sel & rise;
    st.addrLoad = byteDone & (phase == PH_ADDR);
    st.memWrite = byteDone & (phase == PH_WRITE);
    st.addrInc  = byteDone & ((phase == PH_WRITE) | (phase == PH_READ));
    st.fetch    = fetchPend;
    st.txLoad   = sel & fall & (phase == PH_READ) & (bitCnt == 3'd0);
    st.txShift  = sel & fall & (phase == PH_READ) & (bitCnt != 3'd0);
  end

  assign oe = oeQ;

  // R8
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeQ |-> (phase == PH_READ));

  // R7
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SKIP) |-> !oeQ);

  // R9
  deselect_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csSync[1]) |=> (phase == PH_CMD && bitCnt == 3'd0 && !oeQ));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.memWrite, st.addrLoad, st.txLoad, st.txShift}));

endmodule

// File: rtl/spi_sram_dp.sv
module spi_sram_dp
  import spi_sram_pkg::*;
#(
  parameter int unsigned AddrBits = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t st,
  input  logic       sdiBit,
  output logic [7:0] rxByte,
  output logic       sdoBit
);

  localparam int unsigned Depth = 1 << AddrBits;

  logic [6:0]          rxShift;
  logic [AddrBits-1:0] addr;
  logic [7:0]          readBuf;
  logic [7:0]          txReg;
  logic [7:0]          mem [Depth];

  assign rxByte = {rxShift, sdiBit};
  assign sdoBit = txReg[7];

  always_ff @(posedge clk) begin
    if (st.memWrite) mem[addr] <= rxByte;
    if (st.fetch)    readBuf   <= mem[addr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      addr    <= '0;
      txReg   <= '0;
    end else begin
      if (st.shiftIn) rxShift <= {rxShift[5:0], sdiBit};
      if (st.addrLoad)     addr <= AddrBits'({addr, rxByte});
      else if (st.addrInc) addr <= addr + AddrBits'(1);
      if (st.txLoad)       txReg <= readBuf;
      else if (st.txShift) txReg <= {txReg[6:0], 1'b0};
    end
  end

  // R6
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.addrInc && addr == '1) |=> (addr == '0));

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.txLoad && !st.txShift) |=> $stable(txReg));

endmodule

// File: rtl/spi_sram.sv
module spi_sram
  import spi_sram_pkg::*;
#(
  parameter int unsigned AddrBits = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdoOe
);

  dp_strobe_t st;
  logic [7:0] rxByte;
  logic       sdiBit;
  logic       sdoBit;
  logic       oe;

  spi_sram_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .sdi    (sdi),
    .rxByte (rxByte),
    .sdiBit (sdiBit),
    .st     (st),
    .oe     (oe)
  );

  spi_sram_dp #(.AddrBits(AddrBits)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .sdiBit (sdiBit),
    .rxByte (rxByte),
    .sdoBit (sdoBit)
  );

  assign sdo   = oe & sdoBit;
  assign sdoOe = oe;

  // R1
  sdo_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdoOe |-> !sdo);

endmodule

// File: tb/spi_sram_tb.sv
module spi_sram_tb;

  localparam int unsigned AB    = 11;
  localparam int unsigned DEPTH = 1 << AB;
  localparam int unsigned MASK  = DEPTH - 1;
  localparam int unsigned HALF  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdoOe;

  always #2 clk = ~clk;

  spi_sram #(.AddrBits(AB)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe)
  );

  int checks = 0;
  int fails = 0;
  int badBits = 0;
  bit done = 0;
  logic [7:0] refMem [DEPTH];
  logic [7:0] expQ [$];
  string curTag = "";
  bit monOn = 0;

  // scoreboard monitor: assembles sdo bits on rising sclk, pops expectations
  int monBits = 0;
  logic [7:0] monAcc = '0;
  always @(posedge sclk) begin
    if (!monOn) begin
      monBits = 0;
    end else begin
      monAcc = {monAcc[6:0], sdo};
      monBits++;
      if (monBits == 8) begin
        monBits = 0;
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected read byte %02h, expected none", curTag, monAcc);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          if (monAcc !== e) begin
            fails++;
            $display("FAIL %s: read byte %02h, expected %02h", curTag, monAcc, e);
          end
        end
      end
    end
  end

  task automatic bitOut(input logic b, input logic expOe);
    @(negedge clk) sdi = b;
    repeat (HALF - 1) @(negedge clk);
    sclk = 1'b1;
    if (sdoOe !== expOe) badBits++;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic byteOut(input logic [7:0] v, input logic expOe, input string tag);
    badBits = 0;
    for (int i = 7; i >= 0; i--) bitOut(v[i], expOe);
    checks++;
    if (badBits != 0) begin
      fails++;
      $display("FAIL %s: sdoOe wrong on %0d bits, expected %0b", tag, badBits, expOe);
    end
  endtask

  task automatic selLow();
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic selHigh();
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendHeader(input logic [7:0] op, input logic [23:0] a);
    byteOut(op, 1'b0, "R8");
    byteOut(a[23:16], 1'b0, "R8");
    byteOut(a[15:8], 1'b0, "R8");
    byteOut(a[7:0], 1'b0, "R8");
  endtask

  task automatic writeBurst(input logic [23:0] a, input int n, input logic [7:0] seed);
    selLow();
    sendHeader(8'h02, a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed + 8'(i * 37);
      byteOut(d, 1'b0, "R8");
      refMem[(int'(a) + i) & MASK] = d;
    end
    selHigh();
  endtask

  task automatic readBurst(input logic [23:0] a, input int n, input string tag);
    selLow();
    sendHeader(8'h03, a);
    curTag = tag;
    for (int i = 0; i < n; i++) expQ.push_back(refMem[(int'(a) + i) & MASK]);
    monOn = 1;
    for (int i = 0; i < n; i++) byteOut(8'h00, 1'b1, "R8 R4");
    monOn = 0;
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d read bytes missing, expected 0", tag, expQ.size());
      expQ.delete();
    end
    selHigh();
    checks++;
    if (sdoOe !== 1'b0) begin
      fails++;
      $display("FAIL R8: sdoOe after release %0b, expected 0", sdoOe);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (sdoOe !== 1'b0 || sdo !== 1'b0) begin
      fails++;
      $display("FAIL R1: sdoOe/sdo %0b%0b, expected 00", sdoOe, sdo);
    end

    // R2 R3 basic write then read
    writeBurst(24'h000100, 6, 8'hA5);
    readBurst(24'h000100, 6, "R2 R3");
    writeBurst(24'h000200, 4, 8'h3C);
    readBurst(24'h000200, 4, "R3 R4");

    // R6 burst across the top of the array
    writeBurst(24'(MASK - 3), 8, 8'h71);
    readBurst(24'(MASK - 3), 8, "R6");
    readBurst(24'h000000, 4, "R6");

    // R5 upper address bits have no effect
    writeBurst(24'hFFF456, 5, 8'h0F);
    readBurst(24'h000456, 5, "R5");

    // R7 unknown opcode: output stays off, memory untouched
    selLow();
    byteOut(8'h05, 1'b0, "R7");
    byteOut(8'h00, 1'b0, "R7");
    byteOut(8'h01, 1'b0, "R7");
    byteOut(8'h00, 1'b0, "R7");
    for (int i = 0; i < 4; i++) byteOut(8'hEE, 1'b0, "R7");
    selHigh();
    readBurst(24'h000100, 6, "R7");

    // R9 release inside a data byte right after a complete one
    writeBurst(24'h000300, 2, 8'h90);
    selLow();
    sendHeader(8'h02, 24'h000300);
    byteOut(8'h11, 1'b0, "R9");
    refMem[12'h300] = 8'h11;
    for (int i = 0; i < 4; i++) bitOut(1'b1, 1'b0);
    selHigh();
    readBurst(24'h000300, 2, "R9");

    // R9 release inside the opcode byte, then a clean read
    selLow();
    for (int i = 0; i < 3; i++) bitOut(1'b1, 1'b0);
    selHigh();
    readBurst(24'h000300, 1, "R9");

    finishRun();
  end

endmodule